// File: doc/BRIEF.md
# ADC Serial Result Framer

This block is the serial output stage of a converter. It receives parallel result words over a valid/ready stream and sends each word out as a serial master. It generates its own bit clock, data line and frame marker from one system clock. The block never takes a clock from the far end. The host selects:

- a short frame of 16 bit periods or a long frame of 32 bit periods;
- which bit-clock edge launches data;
- for long frames, a one-period marker pulse or a half-frame square wave.

An optional sync input restarts the framing at a known instant. Only the first accepted sync edge acts; the block reports it to the upstream datapath with a one-cycle sequencer-reset pulse. Later sync edges leave the stream alone.

Two framers can share one data line. Each framer has an enable level and a select level, and it drives the line only when the two match. The block signals this with a data output-enable rather than a tristate pad.

Back-pressure on the input stream works through a one-word holding slot. `in_ready` is high while the slot is empty. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. The slot empties at the next frame start, when its word moves to the transmit register. A producer that holds `in_valid` high simply waits. If no new word arrives, the last word is sent again.

Top module: `adc_serial_framer`

## Requirements
- R1: `sclk_o` toggles on every system clock. The only exception is the single cycle in which a resync restarts the bit period. One bit period is therefore two system clocks.
- R2: A frame lasts 16 bit periods when `frame_long_i` is 0 and 32 bit periods when it is 1.
- R3: Each frame carries the held word MSB first in its first 16 bit periods. In a long frame, the last 16 bit periods carry zeros.
- R4: With `edge_sel_i` = 0, `sdata_o` and `fsync_o` change only as `sclk_o` rises, so a receiver samples them on the fall. With `edge_sel_i` = 1 the edges swap. The first system clock after reset is a launch edge and starts frame 0.
- R5: In pulse form, `fsync_o` is high for exactly one bit period at the first bit of each frame. Pulse form applies to every short frame, and to long frames when `sync_square_i` = 0.
- R6: In square form (long frame with `sync_square_i` = 1), `fsync_o` is low for the first 16 bit periods of a frame and high for the last 16.
- R7: `in_ready` is high exactly when the holding slot is empty, and it drops on the clock after a word is accepted. Words are sent in the order they were accepted. A frame with no newer word repeats the previous one.
- R8: The first accepted rising edge of `sync_in_i` has the following effect. If `sync_in_i` is high before clock edge k, then after edge k+1 `seq_rst_o` is high for one cycle. After that same edge, a new frame begins: `sclk_o` is at its launch level, `fsync_o` is high in pulse form, and `sdata_o` holds the word's MSB.
- R9: After the first resync, further `sync_in_i` edges, including a periodic pulse every 32 clocks, neither pulse `seq_rst_o` nor shorten a frame.
- R10: With `frame_long_i` = 1 and `sync_square_i` = 0, `sync_in_i` never causes a resync.
- R11: A pulse-form marker is withheld at any frame start where `sync_in_i` was sampled high on both of the two previous clocks. Markers resume once it is released.
- R12: `sdata_oe_o` is 1 exactly when `line_en_i` equals `line_sel_i`.
- R13: While `rst_n` is low: `sclk_o` equals `edge_sel_i`; `sdata_o`, `fsync_o` and `seq_rst_o` are 0; `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | WORD_W | Result word |
| in_valid | input | 1 | Result word valid |
| in_ready | output | 1 | Holding slot empty |
| frame_long_i | input | 1 | 0: 16-period frame, 1: 32-period frame |
| edge_sel_i | input | 1 | 0: launch on rising bit clock, 1: launch on falling |
| sync_square_i | input | 1 | Square-wave marker in long frames |
| sync_in_i | input | 1 | External frame sync |
| line_en_i | input | 1 | Line-sharing enable level |
| line_sel_i | input | 1 | Line-sharing select level |
| sclk_o | output | 1 | Serial bit clock |
| sdata_o | output | 1 | Serial data |
| sdata_oe_o | output | 1 | Serial data output enable |
| fsync_o | output | 1 | Frame marker |
| seq_rst_o | output | 1 | One-cycle sequencer reset on resync |

## Verification
The bench decodes frames the way a receiver would, sampling on the edge the format selects. A design that launched on the wrong bit-clock edge would change data next to the sampling edge and trip the edge rule. A design that forgot the zero padding or the MSB-first order would decode the wrong word.

The first sync pulse is aimed mid-frame. The bench then expects the restart on an exact cycle, so a resync that lost the MSB or delayed the reset pulse shows up at once. A second sync and a periodic sync follow. A framer that resynchronised every time would emit a truncated frame and a repeated reset pulse.

The ignored-sync and held-sync cases catch a marker that leaks through while sync is high. The two-word burst catches a holding slot that overwrites a word still waiting to be sent.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic {
    FSO_PULSE  = 1'b0,
    FSO_SQUARE = 1'b1
  } fso_form_e;

  function automatic int unsigned sfr_cnt_w(input int unsigned word_w);
    return $clog2(2 * word_w);
  endfunction
endpackage

// File: rtl/sfr_timing.sv
module sfr_timing #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = sfr_pkg::sfr_cnt_w(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_long_i,
  input  logic             resync_i,
  output logic             launch_o,
  output logic             start_o,
  output logic [CNT_W-1:0] idx_n_o,
  output logic             phase_o
);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(2 * WORD_W - 1);

  logic             phase_q;
  logic [CNT_W-1:0] idx_q;
  logic             at_last;

  always_comb begin
    at_last  = idx_q >= (frame_long_i ? LONG_LAST : SHORT_LAST);
    launch_o = ~phase_q | resync_i;
    idx_n_o  = (resync_i | at_last) ? '0 : idx_q + 1'b1;
    start_o  = launch_o & (idx_n_o == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      idx_q   <= LONG_LAST;
    end else begin
      phase_q <= launch_o;
      if (launch_o) idx_q <= idx_n_o;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/sfr_fsi_ctl.sv
module sfr_fsi_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in_i,
  input  logic allowed_i,
  output logic resync_o,
  output logic held_o,
  output logic seq_rst_o
);
  logic smp_q, dly_q, done_q, seq_q;

  assign resync_o  = smp_q & ~dly_q & ~done_q & allowed_i;
  assign held_o    = smp_q & dly_q;
  assign seq_rst_o = seq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b0;
      dly_q  <= 1'b0;
      done_q <= 1'b0;
      seq_q  <= 1'b0;
    end else begin
      smp_q <= sync_in_i;
      dly_q <= smp_q;
      seq_q <= resync_o;
      if (resync_o) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sfr_shifter.sv
module sfr_shifter #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = sfr_pkg::sfr_cnt_w(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              launch_i,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  idx_n_i,
  output logic              sdata_o
);
  logic [WORD_W-1:0] slot_q, cur_q, sh_q, nxt_word;
  logic              slot_v, sd_q;

  assign nxt_word = slot_v ? slot_q : cur_q;
  assign in_ready = ~slot_v;
  assign sdata_o  = sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      slot_v <= 1'b0;
      cur_q  <= '0;
      sh_q   <= '0;
      sd_q   <= 1'b0;
    end else begin
      if (in_valid && !slot_v) begin
        slot_q <= in_data;
        slot_v <= 1'b1;
      end else if (start_i && slot_v) begin
        slot_v <= 1'b0;
      end
      if (start_i) begin
        cur_q <= nxt_word;
        sh_q  <= nxt_word << 1;
        sd_q  <= nxt_word[WORD_W-1];
      end else if (launch_i) begin
        if (idx_n_i < CNT_W'(WORD_W)) begin
          sd_q <= sh_q[WORD_W-1];
          sh_q <= sh_q << 1;
        end else begin
          sd_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/adc_serial_framer.sv
module adc_serial_framer #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = sfr_pkg::sfr_cnt_w(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              frame_long_i,
  input  logic              edge_sel_i,
  input  logic              sync_square_i,
  input  logic              sync_in_i,
  input  logic              line_en_i,
  input  logic              line_sel_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              fsync_o,
  output logic              seq_rst_o
);
  import sfr_pkg::*;

  logic             launch, start, phase, resync, held, allowed;
  logic [CNT_W-1:0] idx_n;
  fso_form_e        form;
  logic             fs_q;

  always_comb begin
    form    = (frame_long_i && sync_square_i) ? FSO_SQUARE : FSO_PULSE;
    allowed = !frame_long_i || sync_square_i;
  end

  sfr_fsi_ctl u_fsi (
    .clk(clk), .rst_n(rst_n), .sync_in_i(sync_in_i), .allowed_i(allowed),
    .resync_o(resync), .held_o(held), .seq_rst_o(seq_rst_o)
  );

  sfr_timing #(.WORD_W(WORD_W)) u_tim (
    .clk(clk), .rst_n(rst_n), .frame_long_i(frame_long_i), .resync_i(resync),
    .launch_o(launch), .start_o(start), .idx_n_o(idx_n), .phase_o(phase)
  );

  sfr_shifter #(.WORD_W(WORD_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .launch_i(launch), .start_i(start),
    .idx_n_i(idx_n), .sdata_o(sdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q <= 1'b0;
    end else if (launch) begin
      case (form)
        FSO_SQUARE: fs_q <= idx_n >= CNT_W'(WORD_W);
        default:    fs_q <= start && !held;
      endcase
    end
  end

  assign fsync_o    = fs_q;
  assign sclk_o     = phase ^ edge_sel_i;
  assign sdata_oe_o = (line_en_i == line_sel_i);
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker (
  input logic clk,
  input logic rst_n,
  input logic sclk_o,
  input logic sdata_o,
  input logic fsync_o,
  input logic edge_sel_i,
  input logic seq_rst_o,
  input logic in_valid,
  input logic in_ready
);
  logic       armed_q;
  logic [1:0] seq_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      seq_cnt_q <= '0;
    end else begin
      armed_q <= 1'b1;
      if (seq_rst_o && seq_cnt_q != 2'd3) seq_cnt_q <= seq_cnt_q + 2'd1;
    end
  end

  // R1: the bit clock flips every cycle outside a resync restart
  a_r1_sclk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !seq_rst_o && $stable(edge_sel_i)) |-> (sclk_o != $past(sclk_o)));

  // R4: data and marker move only together with a launch edge
  a_r4_launch_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && (!$stable(sdata_o) || !$stable(fsync_o))) |-> (sclk_o != edge_sel_i));

  // R8: the sequencer reset lasts a single cycle
  a_r8_seq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rst_o |=> !seq_rst_o);

  // R9: no second sequencer reset after the first resync
  a_r9_seq_once: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rst_o |-> (seq_cnt_q == 2'd0));

  // R7: an accepted word fills the slot
  a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
endmodule

bind adc_serial_framer sfr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_o(sclk_o), .sdata_o(sdata_o),
  .fsync_o(fsync_o), .edge_sel_i(edge_sel_i), .seq_rst_o(seq_rst_o),
  .in_valid(in_valid), .in_ready(in_ready)
);

// File: tb/adc_serial_framer_tb_top.sv
`timescale 1ns/1ps
module adc_serial_framer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] in_data = '0;
  logic in_valid = 1'b0, frame_long = 1'b0, edge_sel = 1'b0, sq = 1'b0;
  logic sync_in = 1'b0, line_en = 1'b0, line_sel = 1'b0;
  logic in_ready, sclk, sdata, sdata_oe, fsync, seq_rst;

  always #4 clk = ~clk;

  adc_serial_framer dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .frame_long_i(frame_long), .edge_sel_i(edge_sel),
    .sync_square_i(sq), .sync_in_i(sync_in), .line_en_i(line_en),
    .line_sel_i(line_sel), .sclk_o(sclk), .sdata_o(sdata),
    .sdata_oe_o(sdata_oe), .fsync_o(fsync), .seq_rst_o(seq_rst)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // receiver model: samples on the edge the format selects
  int unsigned frames_seen = 0;
  logic [31:0] cur_bits, last_bits;
  int cur_len, last_len, cur_fhi, last_fhi;
  logic [31:0] flog [0:1023];
  logic prev_sclk, prev_sd, prev_fs, prev_fsmp, mon_arm;

  always @(negedge clk) begin
    if (!rst_n) begin
      mon_arm = 1'b0; prev_fsmp = 1'b1; cur_len = 0; cur_fhi = 0; cur_bits = '0;
    end else begin
      if (mon_arm) begin
        if (!seq_rst) check(sclk != prev_sclk, "R1 sclk toggle", sclk, ~prev_sclk);
        if (sdata != prev_sd || fsync != prev_fs)
          check(sclk == !edge_sel, "R4 launch edge", sclk, !edge_sel);
      end
      if (sclk != prev_sclk && sclk == edge_sel) begin
        if ((frame_long && sq) ? (prev_fsmp && !fsync) : fsync) begin
          last_bits = cur_bits; last_len = cur_len; last_fhi = cur_fhi;
          flog[frames_seen % 1024] = cur_bits;
          frames_seen++;
          cur_bits = {31'b0, sdata}; cur_len = 1; cur_fhi = int'(fsync);
        end else begin
          cur_bits = {cur_bits[30:0], sdata}; cur_len++; cur_fhi += int'(fsync);
        end
        prev_fsmp = fsync;
      end
      mon_arm = 1'b1;
    end
    prev_sclk = sclk; prev_sd = sdata; prev_fs = fsync;
  end

  function automatic logic [31:0] exp_frame(input logic [15:0] w, input logic lng);
    return lng ? {w, 16'h0} : {16'h0, w};
  endfunction

  task automatic wait_frames(input int n);
    int unsigned tgt = frames_seen + n;
    while (frames_seen < tgt) @(negedge clk);
  endtask

  task automatic push(input logic [15:0] w);
    while (!in_ready) @(negedge clk);
    in_data = w; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_frame(input logic [15:0] w, input string req);
    check(last_bits == exp_frame(w, frame_long), req, last_bits, exp_frame(w, frame_long));
    check(last_len == (frame_long ? 32 : 16), "R2 frame length", last_len, frame_long ? 32 : 16);
    check(last_fhi == ((frame_long && sq) ? 16 : 1), (frame_long && sq) ? "R6 square marker" : "R5 pulse marker",
          last_fhi, (frame_long && sq) ? 16 : 1);
  endtask

  task automatic do_reset(input logic lng, input logic es, input logic s);
    rst_n = 1'b0; sync_in = 1'b0; in_valid = 1'b0;
    frame_long = lng; edge_sel = es; sq = s;
    repeat (3) @(negedge clk);
    check(sclk == es && sdata == 1'b0 && fsync == 1'b0 && seq_rst == 1'b0 && in_ready == 1'b1,
          "R13 reset state", {sclk, sdata, fsync, seq_rst, in_ready}, {es, 4'b0001});
    rst_n = 1'b1;
    @(negedge clk);
    check(sclk == !es, "R4 first launch edge", sclk, !es);
    check(fsync == !(lng && s), "R5 first marker", fsync, !(lng && s));
  endtask

  task automatic run_random(input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] w = 16'($urandom());
      push(w);
      wait_frames(3);
      check_frame(w, "R3 random word");
    end
  endtask

  task automatic sync_pulse();
    sync_in = 1'b1; @(negedge clk); sync_in = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] wa, wb;
    int unsigned base;
    bit seen_a, order_ok, any;
    void'($urandom(32'h1F2E3D4C));

    // short frame, launch on rising edge
    do_reset(1'b0, 1'b0, 1'b0);
    foreach (wa[i]) begin end
    push(16'h8001); wait_frames(3); check_frame(16'h8001, "R3 msb and lsb");
    push(16'hFFFF); wait_frames(3); check_frame(16'hFFFF, "R3 all ones");
    push(16'h0000); wait_frames(3); check_frame(16'h0000, "R3 all zeros");
    push(16'hA5C3); wait_frames(3); check_frame(16'hA5C3, "R3 pattern");
    wait_frames(3); check_frame(16'hA5C3, "R7 repeat last word");
    run_random(10);

    // back-pressure and order
    wa = 16'h1234; wb = 16'hFEDC; base = frames_seen;
    push(wa);
    check(in_ready == 1'b0, "R7 ready drops", in_ready, 1'b0);
    push(wb);
    wait_frames(3);
    seen_a = 1'b0; order_ok = 1'b0;
    for (int unsigned k = base; k < frames_seen; k++) begin
      if (flog[k % 1024] == exp_frame(wa, 1'b0)) seen_a = 1'b1;
      if (flog[k % 1024] == exp_frame(wb, 1'b0) && seen_a) order_ok = 1'b1;
    end
    check(order_ok, "R7 order kept", order_ok, 1'b1);
    check_frame(wb, "R7 second word");

    // line sharing
    for (int c = 0; c < 4; c++) begin
      line_en = c[0]; line_sel = c[1];
      #1 check(sdata_oe == (c[0] == c[1]), "R12 output enable", sdata_oe, c[0] == c[1]);
    end

    // first sync restarts
    wa = 16'hC0DE; push(wa); wait_frames(3);
    wait_frames(1); repeat (9) @(negedge clk);
    sync_in = 1'b1; @(negedge clk); sync_in = 1'b0;
    check(seq_rst == 1'b0, "R8 no early reset", seq_rst, 1'b0);
    @(negedge clk);
    check(seq_rst == 1'b1, "R8 reset pulse", seq_rst, 1'b1);
    check(fsync == 1'b1 && sclk == 1'b1 && sdata == wa[15], "R8 restart frame",
          {fsync, sclk, sdata}, {2'b11, wa[15]});
    @(negedge clk);
    check(seq_rst == 1'b0, "R8 reset one cycle", seq_rst, 1'b0);
    wait_frames(3); check_frame(wa, "R8 word after resync");

    // later syncs are ignored
    wait_frames(1); repeat (9) @(negedge clk);
    any = 1'b0;
    sync_pulse();
    repeat (4) begin @(negedge clk); any |= seq_rst; end
    check(!any, "R9 no second reset", any, 1'b0);
    wait_frames(1); check_frame(wa, "R9 frame intact");
    any = 1'b0;
    for (int p = 0; p < 6; p++) begin
      sync_pulse(); repeat (31) begin @(negedge clk); any |= seq_rst; end
    end
    check(!any, "R9 periodic sync", any, 1'b0);
    wait_frames(1); check_frame(wa, "R9 periodic frame intact");

    // long frame, launch on falling edge, pulse marker
    do_reset(1'b1, 1'b1, 1'b0);
    run_random(6);
    wa = 16'h5A0F; push(wa); wait_frames(3);
    wait_frames(1); repeat (9) @(negedge clk);
    any = 1'b0;
    sync_pulse();
    repeat (4) begin @(negedge clk); any |= seq_rst; end
    check(!any, "R10 sync ignored", any, 1'b0);
    wait_frames(1); check_frame(wa, "R10 frame intact");
    sync_in = 1'b1; any = 1'b0; base = frames_seen;
    repeat (300) begin @(negedge clk); any |= fsync | seq_rst; end
    check(!any && frames_seen == base, "R11 marker held off", any, 1'b0);
    sync_in = 1'b0;
    wait_frames(2); check_frame(wa, "R11 markers resume");

    // long frame, square marker
    do_reset(1'b1, 1'b0, 1'b1);
    run_random(6);

    // short frame, falling launch, square select has no effect
    do_reset(1'b0, 1'b1, 1'b1);
    run_random(5);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule